// File: doc/BRIEF.md
# Multiprocessor-Mode Serial Frame Transmitter

This block is the transmit side of an asynchronous NRZ serial port. A character is written into a one-entry holding buffer. A single sequencing state machine then moves it into a shift register and drives it onto the serial line. The frame carries a start bit, a programmable number of data bits sent least significant bit first, an optional parity bit and one or two stop bits. Two multiprocessor framings are available. In address-bit mode every frame carries an extra bit that marks it as an address or a data frame. In idle-line mode an address frame is preceded by a long run of idle bits.

Bit timing comes from an external baud tick. Internally the tick is divided by eight. A mid-bit pulse advances the shifter and the data-bit counter. An end-of-bit pulse moves the sequencer and updates the line. The wake bit is written together with each character and is latched on every transfer from buffer to shifter. It selects the address-bit value in address-bit mode and the idle preamble in idle-line mode. Two flags are exported. One reports that the holding buffer can accept a character. The other reports that both the buffer and the shifter are empty.

Top module: `sertx_frame_tx`

## Requirements
- R1: While reset is asserted and after it is released, the line is high, the ready flag (txRdy) is 1 and the empty flag (txEmpty) is 1.
- R2: A write while txRdy is 1 captures the data and wake bit, and both txRdy and txEmpty are 0 in the next cycle. A write while txRdy is 0 is ignored and produces no frame.
- R3: Every bit on the line lasts exactly 8 baud ticks. After a frame starts, the line changes only on the tick that completes a multiple of 8.
- R4: The frame begins with a low start bit, followed by cfgCharLen+1 data bits (field value 0 gives 1 bit, 7 gives 8 bits) sent LSB first. Any multiprocessor bit and any parity bit follow the data, and the stop bits come last and are high.
- R5: Buffer bits at or above the programmed character length are never sent and do not affect parity.
- R6: With cfgParityEn=1 a parity bit follows the data and address bits. With cfgParityOdd=0 the count of ones over data, address and parity bits is even. With cfgParityOdd=1 that count is odd.
- R7: With cfgIdleMode=0 (address-bit mode), a single bit follows the data bits, and its value is the wake bit written with that character.
- R8: With cfgIdleMode=1, a character written with wake=1 is preceded by 10 bit times (80 ticks) of high line, counted from the transfer into the shifter. With wake=0 the start bit begins at the transfer. No address bit is sent in this mode.
- R9: With cfgTwoStop=0 the frame ends with one stop bit. With cfgTwoStop=1 it ends with two stop bits.
- R10: txRdy returns to 1 in the cycle after the character moves into the shifter, which is one cycle after the write when the sequencer is idle. A second character can then be written, and it is sent right after the current frame.
- R11: txEmpty rises only at the end of the last stop bit, and only if no character is waiting. It stays 0 across back-to-back frames, and while it is 1 the line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudTick | input | 1 | One-cycle pulse at 8x the bit rate |
| wrEn | input | 1 | Write strobe for the holding buffer |
| wrData | input | DATA_W | Character to send |
| wrWake | input | 1 | Wake bit written with the character |
| cfgCharLen | input | $clog2(DATA_W) | Character length minus one |
| cfgParityEn | input | 1 | Insert a parity bit |
| cfgParityOdd | input | 1 | 1 selects odd parity, 0 even |
| cfgTwoStop | input | 1 | 1 selects two stop bits |
| cfgIdleMode | input | 1 | 1 selects idle-line framing, 0 address-bit framing |
| txd | output | 1 | Serial line, idles high |
| txRdy | output | 1 | Holding buffer can accept a character |
| txEmpty | output | 1 | Buffer and shifter both empty |

## Verification
The assertions assume that the configuration inputs stay fixed while a frame is in progress, from the transfer into the shifter until txEmpty rises, and that baudTick is a single-cycle pulse. The bench changes configuration only after txEmpty has risen and the serial decoder has finished its frame. It generates the tick every third clock. Random characters, wake bits and framings are mixed with directed cases: the shortest character with the upper buffer bits set, a write issued while the buffer is full, and back-to-back frames.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [3:0] {
    ST_STANDBY,
    ST_START,
    ST_DATA,
    ST_ADDR,
    ST_PAR,
    ST_STOP,
    ST_STOP_A,
    ST_STOP_B,
    ST_IDLE_START,
    ST_IDLE_CNT,
    ST_IDLE_STOP
  } txState_e;

  typedef enum logic [2:0] {
    LN_HIGH,
    LN_LOW,
    LN_DATA,
    LN_ADDR,
    LN_PAR
  } lineSel_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic     load;      // buffer -> shifter transfer
    logic     shift;     // advance the shifter one bit
    logic     lineUpd;   // drive a new value on the line
    lineSel_e lineSel;   // what to drive
    logic     frameDone; // last stop bit has ended
  } txCtl_t;

endpackage

// File: rtl/sertx_control.sv
module sertx_control
  import sertx_pkg::*;
#(
  parameter int DIV_W  = 3,
  parameter int LEN_W  = 3,
  parameter int IDLE_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             baudTick,
  input  logic [LEN_W-1:0] cfgCharLen,
  input  logic             cfgParityEn,
  input  logic             cfgTwoStop,
  input  logic             cfgIdleMode,
  input  logic             bufFull,
  input  logic             pendWake,
  output txCtl_t           ctl
);

  localparam int CNT_W = LEN_W + 1;
  localparam logic [DIV_W-1:0] DIV_LAST = '1;
  localparam logic [DIV_W-1:0] DIV_MID  = {1'b0, {(DIV_W-1){1'b1}}};

  txState_e          state, stateNxt;
  logic [DIV_W-1:0]  divCnt;
  logic [CNT_W-1:0]  bitCnt;
  logic [IDLE_W-1:0] idleCnt;
  logic running, workPulse, endPulse, charReached, idleReached;

  assign running     = (state != ST_STANDBY);
  assign workPulse   = running && baudTick && (divCnt == DIV_MID);
  assign endPulse    = running && baudTick && (divCnt == DIV_LAST);
  assign charReached = (bitCnt == ({1'b0, cfgCharLen} + CNT_W'(1)));
  assign idleReached = (idleCnt == '1);

  function automatic lineSel_e lineFor(input txState_e s);
    case (s)
      ST_START: lineFor = LN_LOW;
      ST_DATA:  lineFor = LN_DATA;
      ST_ADDR:  lineFor = LN_ADDR;
      ST_PAR:   lineFor = LN_PAR;
      default:  lineFor = LN_HIGH;
    endcase
  endfunction

  txState_e stopFirst, afterAddr, afterData;
  assign stopFirst = cfgTwoStop ? ST_STOP_A : ST_STOP;
  assign afterAddr = cfgParityEn ? ST_PAR : stopFirst;
  assign afterData = cfgIdleMode ? afterAddr : ST_ADDR;

  always_comb begin
    stateNxt      = state;
    ctl           = '0;
    ctl.lineSel   = LN_HIGH;
    ctl.shift     = workPulse && (state == ST_DATA);
    if (state == ST_STANDBY) begin
      if (bufFull) begin
        ctl.load    = 1'b1;
        stateNxt    = (cfgIdleMode && pendWake) ? ST_IDLE_START : ST_START;
        ctl.lineUpd = 1'b1;
        ctl.lineSel = lineFor(stateNxt);
      end
    end else if (endPulse) begin
      case (state)
        ST_START:      stateNxt = ST_DATA;
        ST_DATA:       stateNxt = charReached ? afterData : ST_DATA;
        ST_ADDR:       stateNxt = afterAddr;
        ST_PAR:        stateNxt = stopFirst;
        ST_STOP_A:     stateNxt = ST_STOP_B;
        ST_IDLE_START: stateNxt = ST_IDLE_CNT;
        ST_IDLE_CNT:   stateNxt = idleReached ? ST_IDLE_STOP : ST_IDLE_CNT;
        ST_IDLE_STOP:  stateNxt = ST_START;
        default: begin
          stateNxt      = ST_STANDBY;
          ctl.frameDone = 1'b1;
        end
      endcase
      ctl.lineUpd = 1'b1;
      ctl.lineSel = lineFor(stateNxt);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_STANDBY;
      divCnt  <= '0;
      bitCnt  <= '0;
      idleCnt <= '0;
    end else begin
      state <= stateNxt;
      if (state == ST_STANDBY) divCnt <= '0;
      else if (baudTick)       divCnt <= divCnt + DIV_W'(1);
      if (state != ST_DATA)    bitCnt <= '0;
      else if (workPulse)      bitCnt <= bitCnt + CNT_W'(1);
      if (state != ST_IDLE_CNT) idleCnt <= '0;
      else if (endPulse)        idleCnt <= idleCnt + IDLE_W'(1);
    end
  end

  // R4: the data-bit count never runs past the programmed length
  p_bitcnt_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_DATA |-> bitCnt <= ({1'b0, cfgCharLen} + CNT_W'(1)));

  // R3: every bit period starts from a cleared divider
  p_div_fresh_r3: assert property (@(posedge clk) disable iff (!rstN)
    (running && $past(state) == ST_STANDBY) |-> divCnt == '0);

  // R6: a parity slot is only visited with parity enabled
  p_par_state_r6: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_PAR |-> cfgParityEn);

  // R7: the address slot exists only in address-bit mode
  p_addr_state_r7: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_ADDR |-> !cfgIdleMode);

  // R8: the idle preamble is entered only in idle-line mode
  p_idle_entry_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE_START && $past(state) == ST_STANDBY) |-> cfgIdleMode);

endmodule

// File: rtl/sertx_datapath.sv
module sertx_datapath
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrWake,
  input  logic [LEN_W-1:0]  cfgCharLen,
  input  logic              cfgParityOdd,
  input  logic              cfgIdleMode,
  input  txCtl_t            ctl,
  output logic              bufFull,
  output logic              pendWake,
  output logic              txd,
  output logic              txRdy,
  output logic              txEmpty
);

  logic [DATA_W-1:0] bufData, shiftReg, charMask;
  logic bufWake, wut, parBit, acceptWr, nextPar;

  assign acceptWr = wrEn && !bufFull;
  assign txRdy    = !bufFull;
  assign pendWake = bufWake;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) charMask[i] = (i <= int'(cfgCharLen));
  end

  assign nextPar = (^(bufData & charMask)) ^ (!cfgIdleMode && bufWake) ^ cfgParityOdd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufData  <= '0;
      bufWake  <= 1'b0;
      bufFull  <= 1'b0;
      shiftReg <= '0;
      wut      <= 1'b0;
      parBit   <= 1'b0;
      txd      <= 1'b1;
      txEmpty  <= 1'b1;
    end else begin
      if (acceptWr) begin
        bufData <= wrData;
        bufWake <= wrWake;
        bufFull <= 1'b1;
      end else if (ctl.load) begin
        bufFull <= 1'b0;
      end
      if (ctl.load) begin
        shiftReg <= bufData & charMask;
        wut      <= bufWake;
        parBit   <= nextPar;
      end else if (ctl.shift) begin
        shiftReg <= shiftReg >> 1;
      end
      if (acceptWr)                       txEmpty <= 1'b0;
      else if (ctl.frameDone && !bufFull) txEmpty <= 1'b1;
      if (ctl.lineUpd) begin
        case (ctl.lineSel)
          LN_LOW:  txd <= 1'b0;
          LN_DATA: txd <= shiftReg[0];
          LN_ADDR: txd <= wut;
          LN_PAR:  txd <= parBit;
          default: txd <= 1'b1;
        endcase
      end
    end
  end

  // R2: an accepted write blocks further writes and marks the block busy
  p_write_takes_r2: assert property (@(posedge clk) disable iff (!rstN)
    acceptWr |=> (!txRdy && !txEmpty));

  // R2: a write into a full buffer leaves its contents alone
  p_full_write_ignored_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && bufFull && !ctl.load) |=> ($stable(bufData) && $stable(bufWake)));

  // R10: the buffer frees up right after the transfer
  p_load_frees_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> txRdy);

  // R11: empty only rises at the end of a frame
  p_empty_at_end_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEmpty) |-> $past(ctl.frameDone));

  // R11: an empty block has a free buffer and a high line
  p_empty_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> (txRdy && txd));

endmodule

// File: rtl/sertx_frame_tx.sv
module sertx_frame_tx
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 3,
  parameter int IDLE_W = 3,
  localparam int LEN_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrWake,
  input  logic [LEN_W-1:0]  cfgCharLen,
  input  logic              cfgParityEn,
  input  logic              cfgParityOdd,
  input  logic              cfgTwoStop,
  input  logic              cfgIdleMode,
  output logic              txd,
  output logic              txRdy,
  output logic              txEmpty
);

  txCtl_t ctl;
  logic   bufFull, pendWake;

  sertx_control #(.DIV_W(DIV_W), .LEN_W(LEN_W), .IDLE_W(IDLE_W)) u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .baudTick    (baudTick),
    .cfgCharLen  (cfgCharLen),
    .cfgParityEn (cfgParityEn),
    .cfgTwoStop  (cfgTwoStop),
    .cfgIdleMode (cfgIdleMode),
    .bufFull     (bufFull),
    .pendWake    (pendWake),
    .ctl         (ctl)
  );

  sertx_datapath #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (wrEn),
    .wrData       (wrData),
    .wrWake       (wrWake),
    .cfgCharLen   (cfgCharLen),
    .cfgParityOdd (cfgParityOdd),
    .cfgIdleMode  (cfgIdleMode),
    .ctl          (ctl),
    .bufFull      (bufFull),
    .pendWake     (pendWake),
    .txd          (txd),
    .txRdy        (txRdy),
    .txEmpty      (txEmpty)
  );

endmodule

// File: tb/sertx_frame_tx_tb.sv
module sertx_frame_tx_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic baudTick = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic wrWake = 1'b0;
  logic [2:0] cfgCharLen = 3'd7;
  logic cfgParityEn = 1'b0, cfgParityOdd = 1'b0, cfgTwoStop = 1'b0, cfgIdleMode = 1'b0;
  logic txd, txRdy, txEmpty;

  int checks = 0, errors = 0, alignBad = 0, emptyBad = 0;
  logic [15:0] rxBits[$];
  int rxLen[$];

  always #4 clk = ~clk;

  sertx_frame_tx u_dut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .wrEn(wrEn), .wrData(wrData),
    .wrWake(wrWake), .cfgCharLen(cfgCharLen), .cfgParityEn(cfgParityEn),
    .cfgParityOdd(cfgParityOdd), .cfgTwoStop(cfgTwoStop), .cfgIdleMode(cfgIdleMode),
    .txd(txd), .txRdy(txRdy), .txEmpty(txEmpty)
  );

  // baud tick every third clock, driven on the falling edge
  initial begin : tickGen
    int phase;
    phase = 0;
    forever begin
      @(negedge clk);
      phase = (phase + 1) % 3;
      baudTick = (phase == 0);
    end
  end

  function automatic int frameLen();
    return 1 + int'(cfgCharLen) + 1 + (cfgIdleMode ? 0 : 1) + (cfgParityEn ? 1 : 0)
           + (cfgTwoStop ? 2 : 1);
  endfunction

  function automatic logic [15:0] expFrame(input logic [7:0] d, input logic w);
    logic [15:0] f;
    logic p;
    int k;
    f = '1;
    f[0] = 1'b0;
    k = 1;
    p = cfgParityOdd;
    for (int i = 0; i <= int'(cfgCharLen); i++) begin
      f[k] = d[i];
      p = p ^ d[i];
      k++;
    end
    if (!cfgIdleMode) begin
      f[k] = w;
      p = p ^ w;
      k++;
    end
    if (cfgParityEn) f[k] = p;
    return f;
  endfunction

  function automatic logic [15:0] lenMask(input int n);
    logic [15:0] m;
    for (int i = 0; i < 16; i++) m[i] = (i < n);
    return m;
  endfunction

  // serial decoder: samples each bit mid-period by counting baud ticks
  initial begin : decoder
    logic [15:0] bits;
    int n, idx, tcount;
    logic prevTxd, t;
    forever begin
      @(posedge clk); #1;
      if (rstN && txd == 1'b0) begin
        n = frameLen();
        bits = '0;
        idx = 0;
        tcount = 0;
        prevTxd = 1'b0;
        while (tcount < 8 * n) begin
          @(posedge clk); t = baudTick; #1;
          if (t) tcount++;
          if (txd !== prevTxd && (tcount % 8) != 0) alignBad++;
          prevTxd = txd;
          if (t && idx < n && tcount == 4 + 8 * idx) begin
            bits[idx] = txd;
            if (txEmpty) emptyBad++;
            idx++;
          end
        end
        rxBits.push_back(bits);
        rxLen.push_back(n);
      end
    end
  end

  task automatic check(input logic ok, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic sendChar(input logic [7:0] d, input logic w);
    @(negedge clk);
    wrEn = 1'b1; wrData = d; wrWake = w;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitFrame();
    while (rxBits.size() == 0) @(negedge clk);
  endtask

  task automatic checkFrame(input logic [7:0] d, input logic w);
    logic [15:0] got, exp;
    int n, en;
    waitFrame();
    got = rxBits.pop_front();
    n = rxLen.pop_front();
    en = frameLen();
    exp = expFrame(d, w) & lenMask(en);
    check(got == exp && n == en, "R4 R5 R6 R7 R9 frame bits", {16'(n), got}, {16'(en), exp});
  endtask

  task automatic runFrame(input logic [7:0] d, input logic w);
    int pre, expPre;
    logic t;
    sendChar(d, w);
    check(!txRdy && !txEmpty, "R2 flags right after write", {txRdy, txEmpty}, 0);
    @(posedge clk); #1;
    check(txRdy == 1'b1, "R10 ready after transfer", txRdy, 1);
    pre = 0;
    while (txd) begin
      @(posedge clk); t = baudTick; #1;
      if (t) pre++;
    end
    expPre = (cfgIdleMode && w) ? 80 : 0;
    check(pre == expPre, "R8 idle preamble ticks", pre, expPre);
    checkFrame(d, w);
    @(negedge clk);
    check(txEmpty == 1'b1, "R11 empty after last stop", txEmpty, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    // R1: idle state during reset
    check(txd && txRdy && txEmpty, "R1 state in reset", {txd, txRdy, txEmpty}, 3'b111);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(txd && txRdy && txEmpty, "R1 state after reset", {txd, txRdy, txEmpty}, 3'b111);

    // R5: shortest character, upper buffer bits set must not leak
    cfgCharLen = 3'd0; cfgParityEn = 1'b1; cfgParityOdd = 1'b0; cfgIdleMode = 1'b1;
    runFrame(8'hFE, 1'b0);

    // R7 R6: full length, address bit set, odd parity, two stops (R9)
    cfgCharLen = 3'd7; cfgParityOdd = 1'b1; cfgTwoStop = 1'b1; cfgIdleMode = 1'b0;
    runFrame(8'hA5, 1'b1);
    runFrame(8'h3C, 1'b0);

    // R8: idle-line mode with and without the wake bit
    cfgIdleMode = 1'b1; cfgTwoStop = 1'b0; cfgParityEn = 1'b0; cfgCharLen = 3'd6;
    runFrame(8'h55, 1'b1);
    runFrame(8'h2B, 1'b0);

    // R2: a write while the buffer is still full is dropped
    cfgIdleMode = 1'b0; cfgCharLen = 3'd4;
    sendChar(8'h11, 1'b0);
    wrEn = 1'b1; wrData = 8'h0E; wrWake = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    checkFrame(8'h11, 1'b0);
    @(negedge clk);
    check(txEmpty == 1'b1, "R11 empty after single frame", txEmpty, 1);
    repeat (400) @(negedge clk);
    check(rxBits.size() == 0, "R2 dropped write made no frame", rxBits.size(), 0);

    // R10 R11: back-to-back frames
    cfgCharLen = 3'd7; cfgParityEn = 1'b1; cfgParityOdd = 1'b0;
    sendChar(8'hC3, 1'b1);
    @(negedge clk);
    check(txRdy == 1'b1, "R10 second write allowed", txRdy, 1);
    sendChar(8'h7E, 1'b0);
    checkFrame(8'hC3, 1'b1);
    check(txEmpty == 1'b0, "R11 empty stays low between frames", txEmpty, 0);
    checkFrame(8'h7E, 1'b0);
    @(negedge clk);
    check(txEmpty == 1'b1, "R11 empty after second frame", txEmpty, 1);

    // random framings and characters
    for (int r = 0; r < 40; r++) begin
      cfgCharLen   = 3'($urandom);
      cfgParityEn  = 1'($urandom);
      cfgParityOdd = 1'($urandom);
      cfgTwoStop   = 1'($urandom);
      cfgIdleMode  = 1'($urandom);
      runFrame(8'($urandom), 1'($urandom));
    end

    check(alignBad == 0, "R3 line edges off the 8-tick grid", alignBad, 0);
    check(emptyBad == 0, "R11 empty seen mid-frame", emptyBad, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule